// File: doc/BRIEF.md
# Active Video Window Locator

This block sits behind the sync inputs of a 1024 × 768 display path. It finds which pixel-clock cycles carry valid picture data. It works from an active-low horizontal sync, an active-low vertical sync, a data-enable input and a mode select.

The block has two ways of finding the window:
- **Fixed mode:** the block counts clocks from each horizontal sync falling edge and lines from each vertical sync falling edge. The visible window starts at programmable horizontal and vertical offsets.
- **Data-enable mode:** the block ignores those offsets and treats each data-enable run as one visible line.

For every clock the block reports:
- a pixel-valid flag and a line-valid flag;
- the column and row of the pixel inside the 1024 × 768 area;
- a sticky flag that is raised when the measured clocks between horizontal sync edges differ from the programmed line length.

A single write strobe loads all three settings: horizontal start, vertical start and clocks per line. A start value that falls in a forbidden low range is raised to the smallest legal value. The same strobe clears the line-length flag.

Top module: `vwin_locator`

## Requirements
- R1: A synchronous reset (rst = 1 at a rising clk edge) drives every output to 0. It loads the settings horizontal start 296, vertical start 35 and clocks per line 1344.
- R2: In fixed mode (de_mode = 0), clock count 0 is the rising edge at which hsync_n is sampled 0 after being sampled 1. The count rises by one on each later edge. The result for an edge is shown on the outputs from that edge until the next one. A count k lies in the horizontal window when hstart <= k < hstart + H_ACT, and its column is k − hstart.
- R3: In fixed mode, line 0 begins at the edge where vsync_n is sampled 0 after 1. The line number rises by one at every later horizontal sync falling edge. line_valid is 1 for lines vstart to vstart + V_ACT − 1, with row = line − vstart. Otherwise row is 0.
- R4: In fixed mode, pix_valid is 1 exactly when both the horizontal and the vertical window hold. col is 0 whenever pix_valid is 0.
- R5: In data-enable mode (de_mode = 1), each run of de_in = 1 numbers its clocks from column 0. Its row is the number of runs that ended since the last vertical sync falling edge. line_valid is 1 while de_in = 1 and row < V_ACT.
- R6: In data-enable mode, pix_valid is 1 only while de_in = 1, col < H_ACT and row < V_ACT. Clocks of a longer run, and runs past the last row, are not valid.
- R7: In fixed mode, de_in has no effect on any output.
- R8: A write (cfg_we = 1) with cfg_hstart below HSTART_MIN stores HSTART_MIN. A new horizontal start applies from the edge after the write.
- R9: A write with cfg_vstart below VSTART_MIN stores VSTART_MIN. A new vertical start applies from the edge after the write.
- R10: At each horizontal sync falling edge after the first one since reset, the clocks since the previous falling edge are compared with the programmed clocks per line. On a difference, len_mismatch is set and stays set.
- R11: A write clears len_mismatch. A write takes priority over a mismatch found at the same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_n | input | 1 | Horizontal sync, active low |
| vsync_n | input | 1 | Vertical sync, active low |
| de_in | input | 1 | Data-enable, high on valid data in data-enable mode |
| de_mode | input | 1 | 1 selects data-enable mode, 0 selects fixed offsets |
| cfg_we | input | 1 | Loads the three settings and clears len_mismatch |
| cfg_hstart | input | HSW (9) | Horizontal start in clocks after the horizontal sync falling edge |
| cfg_vstart | input | VSW (11) | Vertical start in lines after the vertical sync falling edge |
| cfg_hperiod | input | HTW (11) | Expected clocks per line |
| pix_valid | output | 1 | Current pixel is inside the active area |
| line_valid | output | 1 | Current line is inside the active area |
| col | output | clog2(H_ACT) (10) | Column of the valid pixel, 0 otherwise |
| row | output | clog2(V_ACT) (10) | Row of the valid line, 0 otherwise |
| len_mismatch | output | 1 | Sticky line-length mismatch |

## Verification
The main function is tried in fixed mode with de_in toggling at random. Any leak of data-enable into the window would then show up, and the default offsets set where the window falls on each line and frame. Writes with start values below the floors show whether clamping happens and when a new offset applies. Data-enable frames cover runs longer than a line, more runs than rows, and runs that begin at two different back-porch lengths. These frames separate run-based numbering from offset-based numbering. Line-length patterns cover a stretched line after an idle gap, a wrong programmed length, and a write at the same edge as a bad measurement. Together they show whether the flag is sticky and whether the clear takes priority.

// File: rtl/vwin_pkg.sv
`timescale 1ns/1ps
package vwin_pkg;

  // Which source defines the active window
  typedef enum logic {
    SRC_FIXED = 1'b0,
    SRC_DE    = 1'b1
  } vwin_src_e;

  // Raise a value to a lower bound
  function automatic logic [31:0] raise_to_floor(input logic [31:0] v, input logic [31:0] lo);
    return (v < lo) ? lo : v;
  endfunction

endpackage

// File: rtl/vwin_cfg.sv
`timescale 1ns/1ps
module vwin_cfg
  import vwin_pkg::*;
#(
  parameter int HSW         = 9,
  parameter int VSW         = 11,
  parameter int HTW         = 11,
  parameter int HSTART_MIN  = 64,
  parameter int VSTART_MIN  = 4,
  parameter int HSTART_DEF  = 296,
  parameter int VSTART_DEF  = 35,
  parameter int HPERIOD_DEF = 1344
)(
  input  logic           clk,
  input  logic           rst,
  input  logic           we,
  input  logic [HSW-1:0] hstart_in,
  input  logic [VSW-1:0] vstart_in,
  input  logic [HTW-1:0] hperiod_in,
  output logic [HSW-1:0] hstart,
  output logic [VSW-1:0] vstart,
  output logic [HTW-1:0] hperiod
);

  logic [HSW-1:0] hstart_c;
  logic [VSW-1:0] vstart_c;

  always_comb begin
    hstart_c = HSW'(raise_to_floor(32'(hstart_in), 32'(HSTART_MIN)));
    vstart_c = VSW'(raise_to_floor(32'(vstart_in), 32'(VSTART_MIN)));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hstart  <= HSW'(HSTART_DEF);
      vstart  <= VSW'(VSTART_DEF);
      hperiod <= HTW'(HPERIOD_DEF);
    end else if (we) begin
      hstart  <= hstart_c;
      vstart  <= vstart_c;
      hperiod <= hperiod_in;
    end
  end

  AST_HSTART_FLOOR: assert property (@(posedge clk) disable iff (rst)
    32'(hstart) >= HSTART_MIN); // R8
  AST_VSTART_FLOOR: assert property (@(posedge clk) disable iff (rst)
    32'(vstart) >= VSTART_MIN); // R9

endmodule

// File: rtl/vwin_fixed.sv
`timescale 1ns/1ps
module vwin_fixed #(
  parameter int H_ACT = 1024,
  parameter int V_ACT = 768,
  parameter int HSW   = 9,
  parameter int VSW   = 11,
  parameter int HTW   = 11,
  parameter int COLW  = 10,
  parameter int ROWW  = 10
)(
  input  logic             clk,
  input  logic             rst,
  input  logic             hfall,
  input  logic             vfall,
  input  logic [HSW-1:0]   hstart,
  input  logic [VSW-1:0]   vstart,
  output logic [HTW:0]     hcnt_q,
  output logic             hwin,
  output logic             vwin,
  output logic [COLW-1:0]  col_n,
  output logic [ROWW-1:0]  row_n
);

  localparam int HCW = HTW + 1;
  localparam int VLW = VSW + 1;
  localparam logic [HCW-1:0] HC_MAX = {HCW{1'b1}};
  localparam logic [VLW-1:0] VL_MAX = {VLW{1'b1}};

  logic [HCW-1:0] hcnt_n;
  logic [VLW-1:0] vl_q, vl_n;
  logic [HCW-1:0] h_lo, h_hi;
  logic [VLW-1:0] v_lo, v_hi;

  always_comb begin
    hcnt_n = hfall ? '0 : ((hcnt_q == HC_MAX) ? hcnt_q : hcnt_q + 1'b1);
    vl_n   = vl_q;
    if (vfall)
      vl_n = '0;
    else if (hfall && vl_q != VL_MAX)
      vl_n = vl_q + 1'b1;

    h_lo  = HCW'(hstart);
    h_hi  = h_lo + HCW'(H_ACT);
    v_lo  = VLW'(vstart);
    v_hi  = v_lo + VLW'(V_ACT);
    hwin  = (hcnt_n >= h_lo) && (hcnt_n < h_hi);
    vwin  = (vl_n >= v_lo) && (vl_n < v_hi);
    col_n = COLW'(hcnt_n - h_lo);
    row_n = ROWW'(vl_n - v_lo);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hcnt_q <= HC_MAX;
      vl_q   <= VL_MAX;
    end else begin
      hcnt_q <= hcnt_n;
      vl_q   <= vl_n;
    end
  end

  AST_HCOUNT_RESTART: assert property (@(posedge clk) disable iff (rst)
    hfall |=> (hcnt_q == '0)); // R2
  AST_LINE_RESTART: assert property (@(posedge clk) disable iff (rst)
    vfall |=> (vl_q == '0)); // R3

endmodule

// File: rtl/vwin_de.sv
`timescale 1ns/1ps
module vwin_de #(
  parameter int H_ACT = 1024,
  parameter int V_ACT = 768,
  parameter int COLW  = 10,
  parameter int ROWW  = 10
)(
  input  logic            clk,
  input  logic            rst,
  input  logic            de_in,
  input  logic            vfall,
  output logic            de_line,
  output logic            de_pix,
  output logic [COLW-1:0] dcol_o,
  output logic [ROWW-1:0] drow_o
);

  localparam int DCW = COLW + 1;
  localparam int RDW = ROWW + 1;
  localparam logic [DCW-1:0] DC_MAX = {DCW{1'b1}};
  localparam logic [RDW-1:0] RD_MAX = {RDW{1'b1}};

  logic           de_d;
  logic [DCW-1:0] dcol_q, dcol_n;
  logic [RDW-1:0] drow_q, drow_n, rdone_q, rdone_n, cur_rows;
  logic           run_start, run_end;

  always_comb begin
    run_start = de_in & ~de_d;
    run_end   = ~de_in & de_d;
    cur_rows  = vfall ? '0 : rdone_q;
    drow_n    = run_start ? cur_rows : drow_q;
    if (run_start)
      dcol_n = '0;
    else if (de_in && dcol_q != DC_MAX)
      dcol_n = dcol_q + 1'b1;
    else
      dcol_n = dcol_q;
    if (vfall)
      rdone_n = '0;
    else if (run_end && rdone_q != RD_MAX)
      rdone_n = rdone_q + 1'b1;
    else
      rdone_n = rdone_q;

    de_line = de_in && (drow_n < RDW'(V_ACT));
    de_pix  = de_line && (dcol_n < DCW'(H_ACT));
    dcol_o  = COLW'(dcol_n);
    drow_o  = ROWW'(drow_n);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      de_d    <= 1'b0;
      dcol_q  <= '0;
      drow_q  <= '0;
      rdone_q <= '0;
    end else begin
      de_d    <= de_in;
      dcol_q  <= dcol_n;
      drow_q  <= drow_n;
      rdone_q <= rdone_n;
    end
  end

  AST_DE_COL_START: assert property (@(posedge clk) disable iff (rst)
    (de_in && !de_d) |=> (dcol_q == '0)); // R5
  AST_DE_ROWS_CLEAR: assert property (@(posedge clk) disable iff (rst)
    vfall |=> (rdone_q == '0)); // R5

endmodule

// File: rtl/vwin_lenchk.sv
`timescale 1ns/1ps
module vwin_lenchk #(
  parameter int HTW = 11
)(
  input  logic         clk,
  input  logic         rst,
  input  logic         hfall,
  input  logic         clr,
  input  logic [HTW:0] hcnt_q,
  input  logic [HTW-1:0] hperiod,
  output logic         mism
);

  localparam int HCW = HTW + 1;
  localparam logic [HCW-1:0] HC_MAX = {HCW{1'b1}};

  logic           have_ref;
  logic [HCW-1:0] meas;

  always_comb meas = (hcnt_q == HC_MAX) ? hcnt_q : hcnt_q + 1'b1;

  always_ff @(posedge clk) begin
    if (rst) begin
      have_ref <= 1'b0;
      mism     <= 1'b0;
    end else begin
      have_ref <= have_ref | hfall;
      if (clr)
        mism <= 1'b0;
      else if (hfall && have_ref && meas != HCW'(hperiod))
        mism <= 1'b1;
    end
  end

  AST_MISMATCH_STICKY: assert property (@(posedge clk) disable iff (rst)
    (mism && !clr) |=> mism); // R10
  AST_WRITE_CLEARS: assert property (@(posedge clk) disable iff (rst)
    clr |=> !mism); // R11

endmodule

// File: rtl/vwin_locator.sv
`timescale 1ns/1ps
module vwin_locator
  import vwin_pkg::*;
#(
  parameter int H_ACT       = 1024,
  parameter int V_ACT       = 768,
  parameter int HSW         = 9,
  parameter int VSW         = 11,
  parameter int HTW         = 11,
  parameter int HSTART_MIN  = 64,
  parameter int VSTART_MIN  = 4,
  parameter int HSTART_DEF  = 296,
  parameter int VSTART_DEF  = 35,
  parameter int HPERIOD_DEF = 1344
)(
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       hsync_n,
  input  logic                       vsync_n,
  input  logic                       de_in,
  input  logic                       de_mode,
  input  logic                       cfg_we,
  input  logic [HSW-1:0]             cfg_hstart,
  input  logic [VSW-1:0]             cfg_vstart,
  input  logic [HTW-1:0]             cfg_hperiod,
  output logic                       pix_valid,
  output logic                       line_valid,
  output logic [$clog2(H_ACT)-1:0]   col,
  output logic [$clog2(V_ACT)-1:0]   row,
  output logic                       len_mismatch
);

  localparam int COLW = $clog2(H_ACT);
  localparam int ROWW = $clog2(V_ACT);

  logic           hs_d, vs_d, hfall, vfall;
  logic [HSW-1:0] hstart;
  logic [VSW-1:0] vstart;
  logic [HTW-1:0] hperiod;
  logic [HTW:0]   hcnt_q;
  logic           hwin, vwin, de_line, de_pix;
  logic [COLW-1:0] fcol, dcol;
  logic [ROWW-1:0] frow, drow;
  vwin_src_e      src;

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_d <= 1'b1;
      vs_d <= 1'b1;
    end else begin
      hs_d <= hsync_n;
      vs_d <= vsync_n;
    end
  end

  always_comb begin
    hfall = hs_d & ~hsync_n;
    vfall = vs_d & ~vsync_n;
    src   = de_mode ? SRC_DE : SRC_FIXED;
  end

  vwin_cfg #(
    .HSW(HSW), .VSW(VSW), .HTW(HTW),
    .HSTART_MIN(HSTART_MIN), .VSTART_MIN(VSTART_MIN),
    .HSTART_DEF(HSTART_DEF), .VSTART_DEF(VSTART_DEF), .HPERIOD_DEF(HPERIOD_DEF)
  ) u_cfg (
    .clk(clk), .rst(rst), .we(cfg_we),
    .hstart_in(cfg_hstart), .vstart_in(cfg_vstart), .hperiod_in(cfg_hperiod),
    .hstart(hstart), .vstart(vstart), .hperiod(hperiod)
  );

  vwin_fixed #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .HSW(HSW), .VSW(VSW), .HTW(HTW),
    .COLW(COLW), .ROWW(ROWW)
  ) u_fixed (
    .clk(clk), .rst(rst), .hfall(hfall), .vfall(vfall),
    .hstart(hstart), .vstart(vstart), .hcnt_q(hcnt_q),
    .hwin(hwin), .vwin(vwin), .col_n(fcol), .row_n(frow)
  );

  vwin_de #(
    .H_ACT(H_ACT), .V_ACT(V_ACT), .COLW(COLW), .ROWW(ROWW)
  ) u_de (
    .clk(clk), .rst(rst), .de_in(de_in), .vfall(vfall),
    .de_line(de_line), .de_pix(de_pix), .dcol_o(dcol), .drow_o(drow)
  );

  vwin_lenchk #(
    .HTW(HTW)
  ) u_len (
    .clk(clk), .rst(rst), .hfall(hfall), .clr(cfg_we),
    .hcnt_q(hcnt_q), .hperiod(hperiod), .mism(len_mismatch)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pix_valid  <= 1'b0;
      line_valid <= 1'b0;
      col        <= '0;
      row        <= '0;
    end else begin
      case (src)
        SRC_DE: begin
          pix_valid  <= de_pix;
          line_valid <= de_line;
          col        <= de_pix  ? dcol : '0;
          row        <= de_line ? drow : '0;
        end
        default: begin
          pix_valid  <= hwin & vwin;
          line_valid <= vwin;
          col        <= (hwin & vwin) ? fcol : '0;
          row        <= vwin ? frow : '0;
        end
      endcase
    end
  end

  AST_PIX_NEEDS_LINE: assert property (@(posedge clk) disable iff (rst)
    pix_valid |-> line_valid); // R4
  AST_COL_IDLE_ZERO: assert property (@(posedge clk) disable iff (rst)
    !pix_valid |-> (col == '0)); // R4
  AST_ROW_IN_RANGE: assert property (@(posedge clk) disable iff (rst)
    line_valid |-> (32'(row) < V_ACT)); // R3
  AST_DE_PIX_NEEDS_DE: assert property (@(posedge clk) disable iff (rst)
    (pix_valid && $past(de_mode)) |-> $past(de_in)); // R6

endmodule

// File: tb/sim_vwin_locator.sv
`timescale 1ns/1ps
module sim_vwin_locator;

  localparam int H = 8, V = 4, HSW = 9, VSW = 11, HTW = 11;
  localparam int HMIN = 3, VMIN = 2, HDEF = 5, VDEF = 3, PDEF = 20;
  localparam int COLW = $clog2(H), ROWW = $clog2(V);
  localparam int HCMAX = (1 << (HTW + 1)) - 1;
  localparam int VLMAX = (1 << (VSW + 1)) - 1;
  localparam int DCMAX = (1 << (COLW + 1)) - 1;
  localparam int RDMAX = (1 << (ROWW + 1)) - 1;

  logic clk = 1'b0, rst = 1'b1;
  logic hsync_n = 1'b1, vsync_n = 1'b1, de_in = 1'b0, de_mode = 1'b0, cfg_we = 1'b0;
  logic [HSW-1:0] cfg_hstart = '0;
  logic [VSW-1:0] cfg_vstart = '0;
  logic [HTW-1:0] cfg_hperiod = '0;
  logic pix_valid, line_valid, len_mismatch;
  logic [COLW-1:0] col;
  logic [ROWW-1:0] row;

  always #2.5 clk = ~clk;

  vwin_locator #(
    .H_ACT(H), .V_ACT(V), .HSW(HSW), .VSW(VSW), .HTW(HTW),
    .HSTART_MIN(HMIN), .VSTART_MIN(VMIN),
    .HSTART_DEF(HDEF), .VSTART_DEF(VDEF), .HPERIOD_DEF(PDEF)
  ) u0 (
    .clk(clk), .rst(rst), .hsync_n(hsync_n), .vsync_n(vsync_n), .de_in(de_in),
    .de_mode(de_mode), .cfg_we(cfg_we), .cfg_hstart(cfg_hstart),
    .cfg_vstart(cfg_vstart), .cfg_hperiod(cfg_hperiod),
    .pix_valid(pix_valid), .line_valid(line_valid), .col(col), .row(row),
    .len_mismatch(len_mismatch)
  );

  int n_chk = 0, n_fail = 0, cyc = 0, fpix = 0;
  string hreq = "R1", vreq = "R1";

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  // ---------------- behavioural reference model ----------------
  bit armed = 0;
  int m_hsd, m_vsd, m_ded, m_hc, m_vl, m_rd, m_dr, m_dc, m_ref, m_mis;
  int m_hst, m_vst, m_hp;
  int e_pix, e_line, e_col, e_row;
  int hf, vf, dr, dfl, hcn, vln, crw, drn, dcn, rdn, meas, fh, fv;

  always @(posedge clk) begin
    if (rst) begin
      armed = 1;
      m_hsd = 1; m_vsd = 1; m_ded = 0; m_hc = HCMAX; m_vl = VLMAX;
      m_rd = 0; m_dr = 0; m_dc = 0; m_ref = 0; m_mis = 0;
      m_hst = HDEF; m_vst = VDEF; m_hp = PDEF;
      e_pix = 0; e_line = 0; e_col = 0; e_row = 0;
    end else begin
      hf  = (m_hsd == 1 && hsync_n == 1'b0) ? 1 : 0;
      vf  = (m_vsd == 1 && vsync_n == 1'b0) ? 1 : 0;
      dr  = (de_in && m_ded == 0) ? 1 : 0;
      dfl = (!de_in && m_ded == 1) ? 1 : 0;
      hcn = hf ? 0 : ((m_hc == HCMAX) ? m_hc : m_hc + 1);
      if (vf) vln = 0; else if (hf && m_vl != VLMAX) vln = m_vl + 1; else vln = m_vl;
      fh = (hcn >= m_hst && hcn < m_hst + H) ? 1 : 0;
      fv = (vln >= m_vst && vln < m_vst + V) ? 1 : 0;
      crw = vf ? 0 : m_rd;
      drn = dr ? crw : m_dr;
      if (dr) dcn = 0; else if (de_in && m_dc != DCMAX) dcn = m_dc + 1; else dcn = m_dc;
      if (vf) rdn = 0; else if (dfl && m_rd != RDMAX) rdn = m_rd + 1; else rdn = m_rd;
      if (de_mode) begin
        e_line = (de_in && drn < V) ? 1 : 0;
        e_pix  = (e_line == 1 && dcn < H) ? 1 : 0;
        e_col  = e_pix ? dcn : 0;
        e_row  = e_line ? drn : 0;
      end else begin
        e_pix  = fh & fv;
        e_line = fv;
        e_col  = e_pix ? hcn - m_hst : 0;
        e_row  = fv ? vln - m_vst : 0;
      end
      meas = (m_hc == HCMAX) ? m_hc : m_hc + 1;
      if (cfg_we) m_mis = 0;
      else if (hf && m_ref == 1 && meas != m_hp) m_mis = 1;
      if (hf) m_ref = 1;
      m_hsd = hsync_n; m_vsd = vsync_n; m_ded = de_in;
      m_hc = hcn; m_vl = vln; m_rd = rdn; m_dr = drn; m_dc = dcn;
      if (cfg_we) begin
        m_hst = (int'(cfg_hstart) < HMIN) ? HMIN : int'(cfg_hstart);
        m_vst = (int'(cfg_vstart) < VMIN) ? VMIN : int'(cfg_vstart);
        m_hp  = int'(cfg_hperiod);
      end
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (armed) begin
      check(pix_valid == e_pix[0] && int'(col) == e_col, hreq, "pix/col",
            int'(pix_valid) * 1000 + int'(col), e_pix * 1000 + e_col);
      check(line_valid == e_line[0] && int'(row) == e_row, vreq, "line/row",
            int'(line_valid) * 1000 + int'(row), e_line * 1000 + e_row);
      check(len_mismatch == m_mis[0], "R10 R11", "len_mismatch",
            int'(len_mismatch), m_mis);
      fpix += int'(pix_valid);
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 60000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual %0d cycles expected under %0d", cyc, 60000);
      report();
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic drive_line(input int period, input bit vs_lo, input bit de_en,
                            input int de_lo, input int de_len, input bit noise,
                            input bit we_first);
    for (int k = 0; k < period; k++) begin
      hsync_n = (k < 3) ? 1'b0 : 1'b1;
      vsync_n = vs_lo ? 1'b0 : 1'b1;
      if (noise) de_in = 1'($urandom_range(0, 1));
      else de_in = de_en && k >= de_lo && k < de_lo + de_len;
      cfg_we = we_first && (k == 0);
      @(negedge clk);
    end
    cfg_we = 1'b0;
  endtask

  task automatic run_frame(input int period, input int nlines, input int de_first,
                           input int de_lines, input int de_lo, input int de_len,
                           input bit noise);
    fpix = 0;
    for (int l = 0; l < nlines; l++)
      drive_line(period, l < 2, l >= de_first && l < de_first + de_lines,
                 de_lo, de_len, noise, 1'b0);
  endtask

  task automatic write_cfg(input int hs, input int vs, input int hp);
    cfg_hstart = HSW'(hs); cfg_vstart = VSW'(vs); cfg_hperiod = HTW'(hp);
    hsync_n = 1'b1; vsync_n = 1'b1; de_in = 1'b0; cfg_we = 1'b1;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  initial begin
    @(negedge clk);
    repeat (4) @(negedge clk);
    // R1: outputs cleared by reset
    check(!pix_valid && !line_valid && col == '0 && row == '0 && !len_mismatch,
          "R1", "reset outputs",
          int'(pix_valid) + int'(line_valid) + int'(col) + int'(row) + int'(len_mismatch), 0);
    rst = 1'b0;
    @(negedge clk);

    // Fixed mode with default offsets and random de_in: R2 R3 R4 R7 (R1 defaults)
    hreq = "R1 R2 R4 R7"; vreq = "R1 R3 R7";
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b1);
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b1);
    check(fpix == H * V, "R4", "valid pixels per fixed frame", fpix, H * V);
    check(!len_mismatch, "R10", "no flag on matching lines", int'(len_mismatch), 0);

    // Clamped offsets: R8 R9
    write_cfg(1, 0, PDEF);
    hreq = "R8"; vreq = "R9";
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b0);
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b1);
    check(fpix == H * V, "R8", "valid pixels with clamped starts", fpix, H * V);
    check(len_mismatch, "R10", "stretched line sets flag", int'(len_mismatch), 1);

    // New offsets and wrong period: R10 R11
    write_cfg(7, 5, 22);
    hreq = "R2 R4"; vreq = "R3";
    check(!len_mismatch, "R11", "write clears flag", int'(len_mismatch), 0);
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b0);
    check(len_mismatch, "R10", "wrong period sets flag", int'(len_mismatch), 1);
    check(fpix == H * V, "R2", "valid pixels with moved window", fpix, H * V);
    cfg_hstart = 9'd7; cfg_vstart = 11'd5; cfg_hperiod = 11'(PDEF);
    drive_line(PDEF, 1'b0, 1'b0, 0, 0, 1'b0, 1'b1);   // write at a bad edge
    check(!len_mismatch, "R11", "write wins over same-edge mismatch", int'(len_mismatch), 0);
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b0);
    check(!len_mismatch, "R11", "flag stays clear on good lines", int'(len_mismatch), 0);

    // Data-enable mode: long runs and extra runs (R5 R6)
    de_mode = 1'b1;
    hreq = "R5 R6"; vreq = "R5 R6";
    run_frame(PDEF, 10, 2, 5, 6, 10, 1'b0);
    run_frame(PDEF, 10, 2, 5, 6, 10, 1'b0);
    check(fpix == H * V, "R6", "long and extra runs trimmed", fpix, H * V);
    run_frame(PDEF, 10, 4, 4, 2, 8, 1'b0);
    check(fpix == H * V, "R5", "shorter back porch runs", fpix, H * V);

    // Back to fixed mode with de noise: R7
    de_mode = 1'b0;
    hreq = "R7 R4"; vreq = "R7 R3";
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b1);
    run_frame(PDEF, 10, 0, 0, 0, 0, 1'b1);
    check(fpix == H * V, "R7", "de_in ignored in fixed mode", fpix, H * V);

    report();
    $finish;
  end

endmodule